// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the table-walk engine of a memory management unit. When the translation buffer misses, it receives the 32-bit virtual address, the kind of access (read or write, user or supervisor), and the page-table pointer of the current context. It then reads a two-level page table from main memory and returns a 40-bit translation. The result is given as a 28-bit physical page number, a page-size flag and the access rights. If the walk cannot produce a translation, the block reports a fault instead.

Two page sizes are supported. A first-level entry can map a 2 MB page directly, and the walk then ends after one read. Otherwise the entry points to a second-level table of 8-byte entries that map 4 KB pages. The first-level table base is the 27-bit pointer shifted left by 13, so it is 8 KB aligned. Second-level tables are 4 KB aligned. The block keeps one walk in flight. It issues one 32-bit word read at a time on a request/response memory port, and each response may arrive any number of cycles after its request.

Top module: `pt_walker`

## Requirements
- R1: `miss_ready` is high only while no walk is running. A `miss_valid` seen while `miss_ready` is high starts a walk. A `miss_valid` seen while a walk is running is ignored: it causes no memory read and no result.
- R2: The first read of a walk is at address {ptr_base, va[31:21], 2'b00}. `ptr_base` is the value present in the cycle the miss was accepted.
- R3: First-level entry format: bit 31 valid, bit 30 big page, bit 29 write allowed (W), bit 28 user allowed (U), bit 27 execute allowed (X). A valid big-page entry ends the walk after one read. It returns done_ppn = {entry[18:0], va[20:12]} with done_big = 1.
- R4: A valid first-level entry with bit 30 clear is a table pointer, and its bits [27:0] are the second-level base. The second-level entry is read as two words: word 0 at {base, va[20:12], 3'b000}, then word 1 at that address plus 4.
- R5: Second-level word 0 format: bit 31 valid, bits 29/28/27 W/U/X. Word 1 bits [27:0] are the physical page number. A successful 4 KB walk makes three reads and returns done_big = 0.
- R6: An invalid entry at either level produces `fault_valid` with fault_kind = 2'b01 and no further reads. A second-level entry with word 0 invalid costs two reads in total.
- R7: A write to a page whose W is 0, or a user access to a page whose U is 0, produces `fault_valid` with fault_kind = 2'b10 instead of a translation.
- R8: A result is a one-cycle pulse of `done_valid` or of `fault_valid`, never both at once. done_rights = {W, U, X} of the final entry. The next cycle `miss_ready` is high again.
- R9: `mem_req` is a one-cycle pulse. A new request is not issued until the previous read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss request |
| miss_va | input | 32 | Virtual address that missed |
| miss_write | input | 1 | Access is a write |
| miss_user | input | 1 | Access is from user mode |
| ptr_base | input | 27 | Upper 27 bits of the first-level table base |
| miss_ready | output | 1 | Walker idle, can accept a miss |
| mem_req | output | 1 | Word read request pulse |
| mem_addr | output | 40 | Physical byte address of the word read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done_valid | output | 1 | Translation result pulse |
| done_ppn | output | 28 | Physical page number (4 KB granularity) |
| done_big | output | 1 | Result came from a 2 MB page |
| done_rights | output | 3 | {W, U, X} of the mapping |
| fault_valid | output | 1 | Fault result pulse |
| fault_kind | output | 2 | 01 invalid entry, 10 access violation |

## Verification
The hardest case to reach is a miss that arrives while a walk is still waiting on memory. The requirement is that it leaves no trace. To create it, the bench keeps `miss_valid` raised with a different address for several cycles after a walk is accepted. It then checks two things: the result belongs to the first address, and the memory model sees no further reads once the block is idle. Context switches are covered by running the same virtual address under two pointer values whose tables map it to different page sizes. Faults are placed at each level, including a second-level entry whose first word is invalid, so the read count shows that the walk stops early.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 40,
  parameter int PTR_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [VA_W-1:0]   miss_va,
  input  logic              miss_write,
  input  logic              miss_user,
  input  logic [PTR_W-1:0]  ptr_base,
  output logic              miss_ready,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done_valid,
  output logic [PA_W-13:0]  done_ppn,
  output logic              done_big,
  output logic [2:0]        done_rights,
  output logic              fault_valid,
  output logic [1:0]        fault_kind
);
  localparam int PPN_W = PA_W - 12;

  typedef enum logic [3:0] {
    IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT0, L2_REQ1, L2_WAIT1, DONE, FAULT
  } st_t;

  st_t               st;
  logic [VA_W-1:12]  va_q;
  logic              wr_q, usr_q;
  logic [PTR_W-1:0]  base_q;
  logic [PPN_W-1:0]  tbl_q;
  logic [2:0]        rights_q;

  function automatic logic denied(input logic [2:0] r, input logic w, input logic u);
    return (w && !r[2]) || (u && !r[1]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      base_q     <= '0;
      tbl_q      <= '0;
      rights_q   <= '0;
      done_ppn   <= '0;
      done_big   <= 1'b0;
      fault_kind <= 2'b00;
    end else begin
      case (st)
        IDLE: if (miss_valid) begin
          va_q   <= miss_va[VA_W-1:12];
          wr_q   <= miss_write;
          usr_q  <= miss_user;
          base_q <= ptr_base;
          st     <= L1_REQ;
        end
        L1_REQ: st <= L1_WAIT;
        L1_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[31]) begin
            fault_kind <= 2'b01;
            st         <= FAULT;
          end else if (mem_rdata[30]) begin
            rights_q <= mem_rdata[29:27];
            done_ppn <= {mem_rdata[18:0], va_q[20:12]};
            done_big <= 1'b1;
            if (denied(mem_rdata[29:27], wr_q, usr_q)) begin
              fault_kind <= 2'b10;
              st         <= FAULT;
            end else begin
              st <= DONE;
            end
          end else begin
            tbl_q <= mem_rdata[PPN_W-1:0];
            st    <= L2_REQ;
          end
        end
        L2_REQ: st <= L2_WAIT0;
        L2_WAIT0: if (mem_rvalid) begin
          if (!mem_rdata[31]) begin
            fault_kind <= 2'b01;
            st         <= FAULT;
          end else begin
            rights_q <= mem_rdata[29:27];
            st       <= L2_REQ1;
          end
        end
        L2_REQ1: st <= L2_WAIT1;
        L2_WAIT1: if (mem_rvalid) begin
          done_ppn <= mem_rdata[PPN_W-1:0];
          done_big <= 1'b0;
          if (denied(rights_q, wr_q, usr_q)) begin
            fault_kind <= 2'b10;
            st         <= FAULT;
          end else begin
            st <= DONE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign miss_ready  = (st == IDLE);
  assign mem_req     = (st == L1_REQ) || (st == L2_REQ) || (st == L2_REQ1);
  assign done_valid  = (st == DONE);
  assign fault_valid = (st == FAULT);
  assign done_rights = rights_q;

  always_comb begin
    if (st == L1_REQ)
      mem_addr = {base_q, va_q[31:21], 2'b00};
    else
      mem_addr = {tbl_q, va_q[20:12], (st == L2_REQ1), 2'b00};
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !miss_ready);

  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(miss_valid && miss_ready) |->
      mem_req && mem_addr[PA_W-1:13] == $past(ptr_base) &&
      mem_addr[12:2] == $past(miss_va[31:21]));

  p_big_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_big) |-> done_ppn[8:0] == va_q[20:12]);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && fault_valid));

  p_back_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || fault_valid) |=> miss_ready);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        miss_valid = 0, miss_write = 0, miss_user = 0;
  logic [31:0] miss_va = 0;
  logic [26:0] ptr_base = 0;
  logic        miss_ready, mem_req, mem_rvalid = 0;
  logic [39:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic        done_valid, done_big, fault_valid;
  logic [27:0] done_ppn;
  logic [2:0]  done_rights;
  logic [1:0]  fault_kind;

  always #10 clk = ~clk;

  pt_walker dut_i (.*);

  int total = 0, bad = 0, nreq = 0, cnt = 0;
  bit ended = 0;
  logic [39:0] pend;
  logic [31:0] mem [logic [39:0]];

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(pend) ? mem[pend] : 32'h0;
      end
    end
    if (mem_req) begin
      pend <= mem_addr;
      cnt  <= 2;
      nreq <= nreq + 1;
    end
  end

  function automatic logic [39:0] l1a(input logic [26:0] p, input logic [31:0] va);
    return {p, va[31:21], 2'b00};
  endfunction
  function automatic logic [39:0] l2a(input logic [27:0] b, input logic [31:0] va);
    return {b, va[20:12], 3'b000};
  endfunction
  function automatic logic [31:0] big_e(input logic [18:0] p, input logic [2:0] wux);
    return {2'b11, wux, 8'h00, p};
  endfunction
  function automatic logic [31:0] tbl_e(input logic [27:0] b);
    return {4'b1000, b};
  endfunction
  function automatic logic [31:0] w0_e(input logic v, input logic [2:0] wux);
    return {v, 1'b0, wux, 27'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [26:0] P1 = 27'h0001234, P2 = 27'h0005678;
  localparam logic [27:0] T1 = 28'h00ABCD0;
  localparam logic [31:0] VA_A = 32'h0040_3000, VA_B = 32'h0080_5000,
                          VA_C = 32'h00C0_0000, VA_D = 32'h0040_4000,
                          VA_E = 32'h0040_5000;

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input logic [26:0] p,
                      input bit exp_fault, input logic [1:0] exp_kind, input logic [27:0] exp_ppn,
                      input logic exp_big, input logic [2:0] exp_r, input int exp_reads, input string req);
    int n0;
    bit got;
    @(negedge clk);
    n0 = nreq;
    miss_va = va; miss_write = wr; miss_user = usr; ptr_base = p; miss_valid = 1;
    @(negedge clk);
    miss_valid = 0;
    ptr_base = ~p;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (done_valid || fault_valid) got = 1; else @(negedge clk);
    end
    chk(got, req, 0, 1);
    chk(fault_valid == exp_fault && done_valid == !exp_fault, req,
        {fault_valid, done_valid}, {exp_fault, !exp_fault});
    if (exp_fault) chk(fault_kind == exp_kind, req, fault_kind, exp_kind);
    else begin
      chk(done_ppn == exp_ppn, req, done_ppn, exp_ppn);
      chk(done_big == exp_big, req, done_big, exp_big);
      chk(done_rights == exp_r, {req, " R8 rights"}, done_rights, exp_r);
    end
    chk(nreq - n0 == exp_reads, {req, " reads"}, nreq - n0, exp_reads);
    @(negedge clk);
    chk(!done_valid && !fault_valid && miss_ready, "R8 pulse/idle",
        {done_valid, fault_valid, miss_ready}, 3'b001);
  endtask

  task automatic t_reset;
    chk(miss_ready && !mem_req && !done_valid && !fault_valid, "R1 reset",
        {miss_ready, mem_req, done_valid, fault_valid}, 4'b1000);
  endtask

  task automatic t_small;
    walk(VA_A, 0, 0, P1, 0, 0, 28'h1234567, 0, 3'b110, 3, "R4 R5 small page");
    walk(VA_A, 1, 1, P1, 0, 0, 28'h1234567, 0, 3'b110, 3, "R5 R7 user write allowed");
  endtask

  task automatic t_big;
    walk(VA_B, 0, 0, P1, 0, 0, {19'h5A5A5, 9'h005}, 1, 3'b001, 1, "R3 big page");
  endtask

  task automatic t_invalid;
    walk(VA_C, 0, 0, P1, 1, 2'b01, 0, 0, 0, 1, "R6 invalid L1");
    walk(VA_D, 0, 0, P1, 1, 2'b01, 0, 0, 0, 2, "R6 invalid L2");
  endtask

  task automatic t_access;
    walk(VA_B, 1, 0, P1, 1, 2'b10, 0, 0, 0, 1, "R7 write to read-only big");
    walk(VA_B, 0, 1, P1, 1, 2'b10, 0, 0, 0, 1, "R7 user on supervisor big");
    walk(VA_E, 1, 0, P1, 1, 2'b10, 0, 0, 0, 3, "R7 write to read-only small");
  endtask

  task automatic t_context;
    walk(VA_A, 0, 0, P2, 0, 0, {19'h00777, 9'h003}, 1, 3'b111, 1, "R2 context switch");
    walk(VA_A, 0, 0, P1, 0, 0, 28'h1234567, 0, 3'b110, 3, "R2 context back");
  endtask

  task automatic t_busy;
    int n0;
    bit got;
    @(negedge clk);
    n0 = nreq;
    miss_va = VA_A; miss_write = 0; miss_user = 0; ptr_base = P1; miss_valid = 1;
    @(negedge clk);
    chk(!miss_ready, "R1 busy", miss_ready, 0);
    miss_va = VA_B;
    repeat (3) @(negedge clk);
    miss_valid = 0;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (done_valid || fault_valid) got = 1; else @(negedge clk);
    end
    chk(done_valid && done_ppn == 28'h1234567, "R1 result of first miss", done_ppn, 28'h1234567);
    repeat (10) @(negedge clk);
    chk(nreq - n0 == 3 && miss_ready, "R1 ignored miss made no reads", nreq - n0, 3);
  endtask

  initial begin
    mem[l1a(P1, VA_A)] = tbl_e(T1);
    mem[l2a(T1, VA_A)] = w0_e(1, 3'b110);
    mem[l2a(T1, VA_A) + 4] = {4'h0, 28'h1234567};
    mem[l2a(T1, VA_D) + 4] = {4'h0, 28'hFFFFFFF};
    mem[l2a(T1, VA_E)] = w0_e(1, 3'b011);
    mem[l2a(T1, VA_E) + 4] = {4'h0, 28'h0000042};
    mem[l1a(P1, VA_B)] = big_e(19'h5A5A5, 3'b001);
    mem[l1a(P2, VA_A)] = big_e(19'h00777, 3'b111);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_small;
    t_big;
    t_invalid;
    t_access;
    t_context;
    t_busy;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule